// File: doc/BRIEF.md
# Debug Address Space Router

This block takes a 32-bit host or debugger address and works out which physical memory it reaches and how many bytes may be moved in one go. The top eight bits pick a segment and the low 24 bits are an offset inside it. Three segments reach unified, instruction and data memory directly. For these the byte count is cut short so that an access never runs past the end of its 16 MB segment. Two further segments are logical windows. The router raises a request strobe to the matching external window translator in the same cycle and forwards that translator's physical address and byte count. Every other segment is a fault.

A legacy mode input renumbers the segment field before any of this decoding takes place. When the final physical address falls in data memory, the router also watches for the register page, where address bits [15:8] are all ones. It folds such addresses to the bottom 64 KB of data memory. One shadow address inside that page is sent on to the location where the third data map register is kept. The result is registered and appears one cycle after the request.

Top module: `addr_router`

## Requirements
- R1: With legacy mode clear, segments 0x00, 0x01 and 0x02 return class 0 (unified), 1 (instruction) and 2 (data) respectively. Their physical address is the segment number in bits [31:24] and the request offset in bits [23:0].
- R2: For segments 0x00 to 0x02 the granted count is the requested count, reduced where needed so that offset plus count does not exceed 2^24. If the offset is 0xFFFFFE, a request for 8 bytes grants 2.
- R3: With legacy mode set, the segment is first renumbered: 0x00 to 0x10, 0x01 to 0x11, 0x10 to 0x02, 0x11 to 0x01 and 0x12 to 0x00. Any other value is left as it is.
- R4: Segment 0x10 raises `dwin_req` in the cycle of the request. The response then carries `dwin_phys` and `dwin_bytes`.
- R5: Segment 0x11 raises `iwin_req` in the cycle of the request. The response then carries `iwin_phys` and `iwin_bytes`.
- R6: A request returns class 3 (fault) with zero bytes, a zero address and both page flags low in each of these cases: an unmapped segment, a grant of zero bytes, or a translated address whose bits [31:24] are above 0x02.
- R7: For a data-class result whose bits [15:8] are 0xFF, bits [23:16] of the address are cleared and `rsp_reg_page` is set.
- R8: If such a register-page address has low 16 bits equal to SHADOW_ADDR (default 0xFF60), the address becomes segment 2 with low half MAP_LOC (default 0x7FFC). In that case `rsp_map_alias` is set and `rsp_reg_page` stays low.
- R9: `rsp_valid` rises exactly one clock after a cycle with `req_valid` high, and is low otherwise. After reset it is low and the class reads fault.
- R10: The page flags are never set outside the data class. An address in unified memory that has 0xFF in bits [15:8] passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Segment [31:24] and offset [23:0] |
| req_bytes | input | 16 | Requested byte count |
| legacy_map | input | 1 | Apply the legacy segment renumbering |
| dwin_bytes | input | 16 | Byte count granted by the data window translator |
| dwin_phys | input | 32 | Physical address from the data window translator |
| iwin_bytes | input | 16 | Byte count granted by the instruction window translator |
| iwin_phys | input | 32 | Physical address from the instruction window translator |
| dwin_req | output | 1 | Data window translator is used this cycle |
| iwin_req | output | 1 | Instruction window translator is used this cycle |
| rsp_valid | output | 1 | Response present |
| rsp_phys | output | 32 | Resolved physical address |
| rsp_bytes | output | 16 | Granted byte count |
| rsp_class | output | 2 | 0 unified, 1 instruction, 2 data, 3 fault |
| rsp_reg_page | output | 1 | Register-page access in data memory |
| rsp_map_alias | output | 1 | Shadow map-register address redirected |

## Verification
The hardest case to reach is a register-page hit that arrives through a window translator rather than through the direct data segment. The router's own offset path cannot produce it. The bench therefore drives a translated address with 0xFF in bits [15:8] on `dwin_phys`. It also reaches the data window through the legacy renumbering of segment 0x00, so that renumbering and translator forwarding are checked together. Clipping is checked on both sides of the segment end, and each expected response is queued and matched in order against back-to-back requests.

// File: rtl/addr_router_pkg.sv
// Shared definitions for the address router: target classes and segment codes.
package addr_router_pkg;
    typedef enum logic [1:0] {
        TC_UNIFIED = 2'b00,
        TC_INSN    = 2'b01,
        TC_DATA    = 2'b10,
        TC_FAULT   = 2'b11
    } tclass_e;

    localparam int SEG_W = 8;
    localparam logic [SEG_W-1:0] SEG_PHYS_UNI = 8'h00;
    localparam logic [SEG_W-1:0] SEG_PHYS_INS = 8'h01;
    localparam logic [SEG_W-1:0] SEG_PHYS_DAT = 8'h02;
    localparam logic [SEG_W-1:0] SEG_WIN_DAT  = 8'h10;
    localparam logic [SEG_W-1:0] SEG_WIN_INS  = 8'h11;
    localparam logic [SEG_W-1:0] SEG_OLD_UNI  = 8'h12;
endpackage

// File: rtl/ar_seg_remap.sv
// Legacy segment renumbering. Purely combinational.
// Assumes the segment field is SEG_W bits wide. Codes outside the
// renumbering table pass through unchanged.
module ar_seg_remap
    import addr_router_pkg::*;
(
    input  logic             legacy,
    input  logic [SEG_W-1:0] seg_in,
    output logic [SEG_W-1:0] seg_out
);
    // Translate old segment numbering into the current one when legacy is set.
    always_comb begin
        seg_out = seg_in;
        if (legacy) begin
            unique case (seg_in)
                SEG_PHYS_UNI: seg_out = SEG_WIN_DAT;
                SEG_PHYS_INS: seg_out = SEG_WIN_INS;
                SEG_WIN_DAT:  seg_out = SEG_PHYS_DAT;
                SEG_WIN_INS:  seg_out = SEG_PHYS_INS;
                SEG_OLD_UNI:  seg_out = SEG_PHYS_UNI;
                default:      seg_out = seg_in;
            endcase
        end
    end
endmodule

// File: rtl/ar_phys_clip.sv
// Clips a requested byte count so that the access stays inside one
// 2^OFF_W byte segment. Combinational; the offset is within the segment.
module ar_phys_clip #(
    parameter int OFF_W = 24,
    parameter int CNT_W = 16
) (
    input  logic [OFF_W-1:0] off,
    input  logic [CNT_W-1:0] want,
    output logic [CNT_W-1:0] grant
);
    localparam int CMP_W = (CNT_W > OFF_W + 1) ? CNT_W : OFF_W + 1;

    logic [CMP_W-1:0] room;
    logic [CMP_W-1:0] want_w;

    // Bytes left to the end of the segment, and the clipped grant.
    always_comb begin
        room   = CMP_W'({1'b1, {OFF_W{1'b0}}}) - CMP_W'(off);
        want_w = CMP_W'(want);
        grant  = (want_w > room) ? room[CNT_W-1:0] : want;
    end
endmodule

// File: rtl/ar_dmem_page.sv
// Register-page detection inside data memory. For a data-class address
// with bits [15:8] all ones, the middle bits are cleared. One shadow
// address is redirected to the map-register location. Combinational.
module ar_dmem_page #(
    parameter int          ADDR_W      = 32,
    parameter int          OFF_W       = 24,
    parameter logic [15:0] SHADOW_ADDR = 16'hFF60,
    parameter logic [15:0] MAP_LOC     = 16'h7FFC
) (
    input  logic              is_data,
    input  logic [ADDR_W-1:0] phys_in,
    output logic [ADDR_W-1:0] phys_out,
    output logic              reg_page,
    output logic              map_alias
);
    logic [15:0] low;

    // Fold register-page addresses and pick out the shadow alias.
    always_comb begin
        low       = phys_in[15:0];
        phys_out  = phys_in;
        reg_page  = 1'b0;
        map_alias = 1'b0;
        if (is_data && (low[15:8] == 8'hFF)) begin
            if (low == SHADOW_ADDR) begin
                phys_out  = {phys_in[ADDR_W-1:OFF_W], OFF_W'(MAP_LOC)};
                map_alias = 1'b1;
            end else begin
                phys_out  = {phys_in[ADDR_W-1:OFF_W], OFF_W'(low)};
                reg_page  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/addr_router.sv
// Address space router. Splits the address into segment and offset and
// applies the optional legacy renumbering. It resolves physical segments
// directly with clipping, forwards logical segments to external window
// translators, and flags data-memory register-page hits. The response is
// registered with one cycle of latency. The translators answer in the
// request cycle.
module addr_router
    import addr_router_pkg::*;
#(
    parameter int          OFF_W       = 24,
    parameter int          CNT_W       = 16,
    parameter logic [15:0] SHADOW_ADDR = 16'hFF60,
    parameter logic [15:0] MAP_LOC     = 16'h7FFC,
    localparam int         ADDR_W      = OFF_W + SEG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CNT_W-1:0]  req_bytes,
    input  logic              legacy_map,
    input  logic [CNT_W-1:0]  dwin_bytes,
    input  logic [ADDR_W-1:0] dwin_phys,
    input  logic [CNT_W-1:0]  iwin_bytes,
    input  logic [ADDR_W-1:0] iwin_phys,
    output logic              dwin_req,
    output logic              iwin_req,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_phys,
    output logic [CNT_W-1:0]  rsp_bytes,
    output logic [1:0]        rsp_class,
    output logic              rsp_reg_page,
    output logic              rsp_map_alias
);
    logic [SEG_W-1:0]  seg_raw;
    logic [SEG_W-1:0]  seg_eff;
    logic [OFF_W-1:0]  off;
    logic [CNT_W-1:0]  clip_grant;
    logic [ADDR_W-1:0] pre_phys;
    logic [CNT_W-1:0]  pre_bytes;
    tclass_e           pre_class;
    logic [ADDR_W-1:0] page_phys;
    logic              page_reg;
    logic              page_alias;
    logic              is_phys_seg;

    assign seg_raw = req_addr[ADDR_W-1:OFF_W];
    assign off     = req_addr[OFF_W-1:0];

    ar_seg_remap i_remap (
        .legacy  (legacy_map),
        .seg_in  (seg_raw),
        .seg_out (seg_eff)
    );

    ar_phys_clip #(.OFF_W(OFF_W), .CNT_W(CNT_W)) i_clip (
        .off   (off),
        .want  (req_bytes),
        .grant (clip_grant)
    );

    // Select the source of the address and count by segment, then classify.
    always_comb begin
        is_phys_seg = 1'b0;
        pre_phys    = '0;
        pre_bytes   = '0;
        dwin_req    = 1'b0;
        iwin_req    = 1'b0;
        unique case (seg_eff)
            SEG_PHYS_UNI, SEG_PHYS_INS, SEG_PHYS_DAT: begin
                is_phys_seg = 1'b1;
                pre_phys    = {seg_eff, off};
                pre_bytes   = clip_grant;
            end
            SEG_WIN_DAT: begin
                dwin_req  = req_valid;
                pre_phys  = dwin_phys;
                pre_bytes = dwin_bytes;
            end
            SEG_WIN_INS: begin
                iwin_req  = req_valid;
                pre_phys  = iwin_phys;
                pre_bytes = iwin_bytes;
            end
            default: ;
        endcase
        unique case (pre_phys[ADDR_W-1:OFF_W])
            SEG_PHYS_UNI: pre_class = TC_UNIFIED;
            SEG_PHYS_INS: pre_class = TC_INSN;
            SEG_PHYS_DAT: pre_class = TC_DATA;
            default:      pre_class = TC_FAULT;
        endcase
        if (pre_bytes == '0) pre_class = TC_FAULT;
        if (pre_class == TC_FAULT) begin
            pre_phys  = '0;
            pre_bytes = '0;
        end
    end

    ar_dmem_page #(
        .ADDR_W      (ADDR_W),
        .OFF_W       (OFF_W),
        .SHADOW_ADDR (SHADOW_ADDR),
        .MAP_LOC     (MAP_LOC)
    ) i_page (
        .is_data   (pre_class == TC_DATA),
        .phys_in   (pre_phys),
        .phys_out  (page_phys),
        .reg_page  (page_reg),
        .map_alias (page_alias)
    );

    // Response register: one cycle of latency, fault class at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_phys      <= '0;
            rsp_bytes     <= '0;
            rsp_class     <= TC_FAULT;
            rsp_reg_page  <= 1'b0;
            rsp_map_alias <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_phys      <= page_phys;
                rsp_bytes     <= pre_bytes;
                rsp_class     <= pre_class;
                rsp_reg_page  <= page_reg;
                rsp_map_alias <= page_alias;
            end
        end
    end

    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R9
    AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R9
    AST_CLIP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && is_phys_seg) |=> (rsp_bytes <= $past(req_bytes))); // R2
    AST_LEGACY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && legacy_map && seg_raw == SEG_PHYS_UNI) |-> dwin_req); // R3
    AST_FAULT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_class == TC_FAULT) |-> (rsp_bytes == '0 && rsp_phys == '0)); // R6
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_reg_page, rsp_map_alias})); // R8
    AST_FLAGS_DATA_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_reg_page || rsp_map_alias) |-> rsp_class == TC_DATA); // R10
endmodule

// File: tb/test_addr_router.sv
// Scoreboard bench for addr_router. The driver pushes expected responses
// computed from the requirements; the monitor pops and compares them.
module test_addr_router;
    localparam int OFF_W = 24;
    localparam int CNT_W = 16;
    localparam int ADDR_W = 32;

    typedef struct {
        string       tag;
        logic [31:0] phys;
        logic [15:0] bytes;
        logic [1:0]  cls;
        logic        rp;
        logic        ma;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [31:0]       req_addr = '0;
    logic [15:0]       req_bytes = '0;
    logic              legacy_map = 1'b0;
    logic [15:0]       dwin_bytes = '0;
    logic [31:0]       dwin_phys = '0;
    logic [15:0]       iwin_bytes = '0;
    logic [31:0]       iwin_phys = '0;
    logic              dwin_req, iwin_req, rsp_valid, rsp_reg_page, rsp_map_alias;
    logic [31:0]       rsp_phys;
    logic [15:0]       rsp_bytes;
    logic [1:0]        rsp_class;

    int   checks = 0;
    int   errors = 0;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    addr_router i_addr_router (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_bytes(req_bytes), .legacy_map(legacy_map), .dwin_bytes(dwin_bytes),
        .dwin_phys(dwin_phys), .iwin_bytes(iwin_bytes), .iwin_phys(iwin_phys),
        .dwin_req(dwin_req), .iwin_req(iwin_req), .rsp_valid(rsp_valid),
        .rsp_phys(rsp_phys), .rsp_bytes(rsp_bytes), .rsp_class(rsp_class),
        .rsp_reg_page(rsp_reg_page), .rsp_map_alias(rsp_map_alias)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected segment after the legacy renumbering (R3).
    function automatic logic [7:0] model_seg(input logic leg, input logic [7:0] s);
        if (!leg) return s;
        case (s)
            8'h00: return 8'h10;
            8'h01: return 8'h11;
            8'h10: return 8'h02;
            8'h11: return 8'h01;
            8'h12: return 8'h00;
            default: return s;
        endcase
    endfunction

    // Reference response built from R1..R10.
    function automatic exp_t model(input string tag, input logic leg, input logic [31:0] a,
                                   input logic [15:0] n, input logic [31:0] dp,
                                   input logic [15:0] dn, input logic [31:0] ip,
                                   input logic [15:0] in_n);
        exp_t e;
        logic [7:0]  s;
        logic [31:0] room;
        e.tag = tag; e.rp = 1'b0; e.ma = 1'b0;
        s = model_seg(leg, a[31:24]);
        if (s <= 8'h02) begin
            room = 32'h0100_0000 - {8'h00, a[23:0]};
            e.phys  = {s, a[23:0]};
            e.bytes = ({16'h0, n} > room) ? room[15:0] : n;
        end else if (s == 8'h10) begin
            e.phys = dp; e.bytes = dn;
        end else if (s == 8'h11) begin
            e.phys = ip; e.bytes = in_n;
        end else begin
            e.phys = '0; e.bytes = '0;
        end
        e.cls = (e.phys[31:24] > 8'h02) ? 2'd3 : e.phys[25:24];
        if (e.bytes == 0) e.cls = 2'd3;
        if (e.cls == 2'd3) begin
            e.phys = '0; e.bytes = '0;
        end
        if (e.cls == 2'd2 && e.phys[15:8] == 8'hFF) begin
            if (e.phys[15:0] == 16'hFF60) begin
                e.phys = 32'h0200_7FFC; e.ma = 1'b1;
            end else begin
                e.phys = {8'h02, 8'h00, e.phys[15:0]}; e.rp = 1'b1;
            end
        end
        return e;
    endfunction

    // Driver: one request per call, back to back; also checks window strobes.
    task automatic send(input string tag, input logic leg, input logic [31:0] a,
                        input logic [15:0] n, input logic [31:0] dp = 32'h0,
                        input logic [15:0] dn = 16'h0, input logic [31:0] ip = 32'h0,
                        input logic [15:0] in_n = 16'h0);
        logic [7:0] s;
        @(negedge clk);
        req_valid = 1'b1; legacy_map = leg; req_addr = a; req_bytes = n;
        dwin_phys = dp; dwin_bytes = dn; iwin_phys = ip; iwin_bytes = in_n;
        sb_q.push_back(model(tag, leg, a, n, dp, dn, ip, in_n));
        #1;
        s = model_seg(leg, a[31:24]);
        check({tag, " dwin_req"}, {31'h0, dwin_req}, {31'h0, s == 8'h10});
        check({tag, " iwin_req"}, {31'h0, iwin_req}, {31'h0, s == 8'h11});
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    // Monitor: compare each response against the head of the scoreboard.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && rsp_valid) begin
                if (sb_q.size() == 0) begin
                    check("R9 unexpected rsp_valid", 32'h1, 32'h0);
                end else begin
                    e = sb_q.pop_front();
                    check({e.tag, " phys"}, rsp_phys, e.phys);
                    check({e.tag, " bytes"}, {16'h0, rsp_bytes}, {16'h0, e.bytes});
                    check({e.tag, " class"}, {30'h0, rsp_class}, {30'h0, e.cls});
                    check({e.tag, " reg_page"}, {31'h0, rsp_reg_page}, {31'h0, e.rp});
                    check({e.tag, " map_alias"}, {31'h0, rsp_map_alias}, {31'h0, e.ma});
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R9 reset rsp_valid", {31'h0, rsp_valid}, 32'h0);
        check("R9 reset class fault", {30'h0, rsp_class}, 32'h3);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 physical segments
        send("R1 unified", 1'b0, 32'h0000_1234, 16'd8);
        send("R1 insn", 1'b0, 32'h0100_0100, 16'd4);
        send("R1 data", 1'b0, 32'h0200_4000, 16'd2);
        // R2 clipping at the segment end
        send("R2 clip", 1'b0, 32'h00FF_FFFE, 16'd8);
        send("R2 exact fit", 1'b0, 32'h01FF_FFF8, 16'd8);
        send("R2 last byte", 1'b0, 32'h02FF_FFFF, 16'd4);
        idle(2);
        // R3 legacy renumbering
        send("R3 old unified", 1'b1, 32'h1200_0040, 16'd4);
        send("R3 old data", 1'b1, 32'h1000_0080, 16'd4);
        send("R3 old dwin", 1'b1, 32'h0000_0010, 16'd4, 32'h0200_3000, 16'd6);
        send("R3 old insn", 1'b1, 32'h1100_0200, 16'd4);
        send("R3 old iwin", 1'b1, 32'h0100_0000, 16'd4, 32'h0, 16'h0, 32'h0100_0400, 16'd4);
        send("R3 passthru fault", 1'b1, 32'h0500_0000, 16'd4);
        send("R3 no legacy 0x12", 1'b0, 32'h1200_0000, 16'd4);
        // R4 / R5 window forwarding
        send("R4 dwin data", 1'b0, 32'h1000_0000, 16'd4, 32'h0200_3000, 16'd6);
        send("R4 dwin unified", 1'b0, 32'h1000_0004, 16'd4, 32'h00AB_CDEF, 16'd3);
        send("R5 iwin insn", 1'b0, 32'h1100_0000, 16'd4, 32'h0, 16'h0, 32'h0100_0400, 16'd4);
        idle(1);
        // R6 faults
        send("R6 unmapped", 1'b0, 32'h0300_0000, 16'd4);
        send("R6 zero grant", 1'b0, 32'h1000_0000, 16'd4, 32'h0200_1000, 16'd0);
        send("R6 bad translated seg", 1'b0, 32'h1000_0000, 16'd4, 32'h0500_0000, 16'd4);
        send("R6 zero request", 1'b0, 32'h0000_0010, 16'd0);
        // R7 / R8 register page
        send("R7 reg page direct", 1'b0, 32'h0212_FF34, 16'd2);
        send("R7 reg page via dwin", 1'b0, 32'h1000_0000, 16'd2, 32'h0234_FF00, 16'd2);
        send("R8 shadow alias", 1'b0, 32'h0200_FF60, 16'd2);
        send("R8 shadow via dwin", 1'b0, 32'h1000_0000, 16'd2, 32'h0277_FF60, 16'd2);
        // R10 no flags outside data
        send("R10 unified FF page", 1'b0, 32'h0000_FF60, 16'd2);
        send("R10 insn FF page", 1'b0, 32'h0112_FF34, 16'd2);
        idle(4);
        check("R9 all responses seen", sb_q.size(), 32'h0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule